// File: doc/BRIEF.md
# Single-Channel Dual-Address DMA Engine

This block is one DMA channel that software sets up through five registers and then starts. It moves a block of bytes over a 32-bit memory bus that uses a request/acknowledge handshake. In dual-address mode, each transfer is a read at the source followed by a write of the same data at the destination. Between the two, the engine moves the bytes from the source lanes to the destination lanes, so 8-bit and 16-bit devices see their data on the lanes their address selects. In single-address mode, each transfer is one bus cycle at one address. The peripheral takes the data, or supplies it, directly.

A transfer can start as soon as software issues go. It can also wait for a peripheral request line. In that case the channel either makes one transfer for each request edge (cycle-steal) or runs to the end after the first edge. A byte counter tracks the work left. Completion sets a done flag, which can raise an interrupt. A write to the status register clears the flags and aborts the channel.

Top module: `dmx_chan`

## Requirements
- R1: Registers are chosen by reg_sel: 0 = source address, 1 = destination address, 2 = byte count (16 bits), 3 = control, 4 = status. Status reads {err (bit 2), busy (bit 1), done (bit 0)}. After reset every register reads zero and bus_req and irq are low.
- R2: In dual-address mode (control bit 3 = 0), each transfer is a read (bus_we = 0) at the source address. It is followed by a write (bus_we = 1) at the destination address. No other bus cycles occur.
- R3: bus_addr carries the full byte address, and bus_be enables the size-wide lanes that start at address bits [1:0] (byte at address a sits on lane a[1:0], little-endian). In a write, the bytes read from the source lanes appear on the destination lanes.
- R4: The source size code (control bits [8:7]) and the destination size code (bits [10:9]) use 0 = 4 bytes, 1 = 1 byte, 2 = 2 bytes. Each transfer reduces the count by that size. When the count reaches zero, busy clears and done sets.
- R5: Control bit 5 enables stepping of the source address and control bit 6 enables stepping of the destination address. A stepping address advances by the size after every transfer, and a static address keeps its value.
- R6: Single-address mode (control bit 3 = 1) makes one bus cycle per transfer. With control bit 4 = 1 (memory to I/O) the cycle is a read at the source address. With bit 4 = 0 it is a write at the destination address with bus_wdata zero.
- R7: With the request enable (control bit 1) and cycle-steal (control bit 2) both set, go only arms the channel. The channel then makes exactly one transfer for each rising edge of dreq.
- R8: With the request enable set and cycle-steal clear, the first rising edge of dreq runs every transfer to completion. With the request enable clear, go (control bit 0, write-only) starts the same continuous run at once.
- R9: A control write made while busy takes only the request-enable bit. Once that bit is clear, dreq edges start no transfer.
- R10: A status write with bit 0 set clears done and err, ends any transfer at once, and drops bus_req.
- R11: irq is high exactly while done is set and the interrupt enable (control bit 11) is set.
- R12: Go is refused and err is set, with no bus cycle, in any of these cases: size code 3; unequal sizes in dual mode; a zero count; a count that is not a multiple of the size; or a used address not aligned to the size.
- R13: While busy, writes to the source, destination and count registers are ignored.
- R14: Once bus_req is raised, bus_addr and bus_we hold their values until bus_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| dreq | input | 1 | Peripheral transfer request |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | AW | Byte address |
| bus_wdata | output | 32 | Write data, lane-steered |
| bus_be | output | 4 | Byte lane enables |
| bus_rdata | input | 32 | Read data |
| bus_ack | input | 1 | Bus cycle complete |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest states to reach are a channel that is armed but idle between cycle-steal requests, and an abort that arrives while a bus cycle is still open. The bench pulses dreq one edge at a time and reads the count between pulses to catch the parked state. It aborts a long 32-bit run a few cycles after go, while the memory model is still answering. A delayed-acknowledge setting in the memory model holds bus cycles open, so the bench can check that the address stays stable.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
    typedef enum logic [2:0] {ST_IDLE, ST_WAIT, ST_RD, ST_WR, ST_XF} dmx_state_e;

    localparam logic [2:0] SEL_SRC = 3'd0;
    localparam logic [2:0] SEL_DST = 3'd1;
    localparam logic [2:0] SEL_CNT = 3'd2;
    localparam logic [2:0] SEL_CTL = 3'd3;
    localparam logic [2:0] SEL_STS = 3'd4;

    localparam int CTL_W    = 12;
    localparam int C_GO     = 0;
    localparam int C_REQEN  = 1;
    localparam int C_STEAL  = 2;
    localparam int C_SINGLE = 3;
    localparam int C_TOIO   = 4;
    localparam int C_SINC   = 5;
    localparam int C_DINC   = 6;
    localparam int C_SSZ    = 7;
    localparam int C_DSZ    = 9;
    localparam int C_IE     = 11;

    // size code to bytes; 0 marks an unsupported code
    function automatic logic [2:0] unit_bytes(input logic [1:0] code);
        case (code)
            2'd0:    unit_bytes = 3'd4;
            2'd1:    unit_bytes = 3'd1;
            2'd2:    unit_bytes = 3'd2;
            default: unit_bytes = 3'd0;
        endcase
    endfunction

    function automatic logic [3:0] lane_mask(input logic [2:0] nbytes, input logic [1:0] lo);
        logic [3:0] base;
        base = (nbytes == 3'd4) ? 4'hF : (nbytes == 3'd2) ? 4'h3 : (nbytes == 3'd1) ? 4'h1 : 4'h0;
        lane_mask = base << lo;
    endfunction
endpackage

// File: rtl/dmx_cfg_chk.sv
module dmx_cfg_chk
    import dmx_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic [1:0]    ssz,
    input  logic [1:0]    dsz,
    input  logic          single,
    input  logic          toio,
    input  logic [1:0]    src_lo,
    input  logic [1:0]    dst_lo,
    input  logic [CW-1:0] cnt,
    output logic          bad
);
    logic [2:0] nb;
    logic [1:0] amask;
    logic       use_src, use_dst;

    always_comb begin
        nb      = unit_bytes(ssz);
        amask   = 2'(nb - 3'd1);
        use_src = !single || toio;
        use_dst = !single || !toio;
        bad = (nb == 3'd0)
            || (!single && (dsz != ssz))
            || (cnt == '0)
            || ((cnt[1:0] & amask) != 2'd0)
            || (use_src && ((src_lo & amask) != 2'd0))
            || (use_dst && ((dst_lo & amask) != 2'd0));
    end
endmodule

// File: rtl/dmx_lane.sv
module dmx_lane
    import dmx_pkg::*;
(
    input  logic [31:0] word,
    input  logic [1:0]  src_lo,
    input  logic [1:0]  dst_lo,
    input  logic [2:0]  nbytes,
    output logic [31:0] placed,
    output logic [3:0]  be
);
    logic [31:0] shifted, keep;

    always_comb begin
        shifted = word >> {src_lo, 3'b000};
        keep    = (nbytes == 3'd4) ? 32'hFFFF_FFFF : (nbytes == 3'd2) ? 32'h0000_FFFF : 32'h0000_00FF;
        placed  = (shifted & keep) << {dst_lo, 3'b000};
        be      = lane_mask(nbytes, dst_lo);
    end
endmodule

// File: rtl/dmx_chan.sv
module dmx_chan
    import dmx_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_sel,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          dreq,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [31:0]   bus_wdata,
    output logic [3:0]    bus_be,
    input  logic [31:0]   bus_rdata,
    input  logic          bus_ack,
    output logic          irq
);
    typedef struct packed {
        dmx_state_e        st;
        logic [AW-1:0]     src;
        logic [AW-1:0]     dst;
        logic [CW-1:0]     cnt;
        logic [CTL_W-1:1]  ctl;
        logic              done;
        logic              err;
        logic              pend;
        logic              dreq_q;
        logic [31:0]       hold;
    } chan_t;

    chan_t q, d;

    logic        cfg_bad, req_edge, busy, last, abort_w;
    logic [2:0]  nb;
    logic [31:0] lane_data;
    logic [3:0]  lane_be;
    logic [AW-1:0] xf_addr;

    dmx_cfg_chk #(.CW(CW)) u_cfg (
        .ssz    (reg_wdata[C_SSZ +: 2]),
        .dsz    (reg_wdata[C_DSZ +: 2]),
        .single (reg_wdata[C_SINGLE]),
        .toio   (reg_wdata[C_TOIO]),
        .src_lo (q.src[1:0]),
        .dst_lo (q.dst[1:0]),
        .cnt    (q.cnt),
        .bad    (cfg_bad)
    );

    dmx_lane u_lane (
        .word   (q.hold),
        .src_lo (q.src[1:0]),
        .dst_lo (q.dst[1:0]),
        .nbytes (nb),
        .placed (lane_data),
        .be     (lane_be)
    );

    always_comb begin
        d        = q;
        d.dreq_q = dreq;
        busy     = (q.st != ST_IDLE);
        nb       = unit_bytes(q.ctl[C_SSZ +: 2]);
        last     = (q.cnt == CW'(nb));
        req_edge = dreq && !q.dreq_q && q.ctl[C_REQEN];
        abort_w  = reg_we && (reg_sel == SEL_STS) && reg_wdata[0];

        if (req_edge && busy) d.pend = 1'b1;

        // transfer sequencer
        case (q.st)
            ST_WAIT: if (q.pend || req_edge) begin
                d.pend = 1'b0;
                d.st   = q.ctl[C_SINGLE] ? ST_XF : ST_RD;
            end
            ST_RD: if (bus_ack) begin
                d.hold = bus_rdata;
                d.st   = ST_WR;
            end
            ST_WR, ST_XF: if (bus_ack) begin
                d.src = q.src + (q.ctl[C_SINC] ? AW'(nb) : '0);
                d.dst = q.dst + (q.ctl[C_DINC] ? AW'(nb) : '0);
                d.cnt = q.cnt - CW'(nb);
                if (last) begin
                    d.done = 1'b1;
                    d.pend = 1'b0;
                    d.st   = ST_IDLE;
                end else if (q.ctl[C_STEAL] && q.ctl[C_REQEN]) begin
                    d.st = ST_WAIT;
                end else begin
                    d.st = q.ctl[C_SINGLE] ? ST_XF : ST_RD;
                end
            end
            default: ;
        endcase

        // register bank
        if (reg_we) begin
            case (reg_sel)
                SEL_SRC: if (!busy) d.src = reg_wdata[AW-1:0];
                SEL_DST: if (!busy) d.dst = reg_wdata[AW-1:0];
                SEL_CNT: if (!busy) d.cnt = reg_wdata[CW-1:0];
                SEL_CTL: begin
                    if (busy) begin
                        d.ctl[C_REQEN] = reg_wdata[C_REQEN];
                    end else begin
                        d.ctl = reg_wdata[CTL_W-1:1];
                        if (reg_wdata[C_GO]) begin
                            d.done = 1'b0;
                            d.pend = 1'b0;
                            if (cfg_bad) begin
                                d.err = 1'b1;
                            end else begin
                                d.err = 1'b0;
                                d.st  = reg_wdata[C_REQEN] ? ST_WAIT :
                                        (reg_wdata[C_SINGLE] ? ST_XF : ST_RD);
                            end
                        end
                    end
                end
                SEL_STS: if (reg_wdata[0]) begin
                    d.done = 1'b0;
                    d.err  = 1'b0;
                    d.pend = 1'b0;
                    d.st   = ST_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        xf_addr   = q.ctl[C_TOIO] ? q.src : q.dst;
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        bus_be    = '0;
        case (q.st)
            ST_RD: begin
                bus_req  = 1'b1;
                bus_addr = q.src;
                bus_be   = lane_mask(nb, q.src[1:0]);
            end
            ST_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = q.dst;
                bus_wdata = lane_data;
                bus_be    = lane_be;
            end
            ST_XF: begin
                bus_req  = 1'b1;
                bus_we   = !q.ctl[C_TOIO];
                bus_addr = xf_addr;
                bus_be   = lane_mask(nb, xf_addr[1:0]);
            end
            default: ;
        endcase
        irq = q.done && q.ctl[C_IE];
    end

    always_comb begin
        case (reg_sel)
            SEL_SRC: reg_rdata = 32'(q.src);
            SEL_DST: reg_rdata = 32'(q.dst);
            SEL_CNT: reg_rdata = 32'(q.cnt);
            SEL_CTL: reg_rdata = 32'({q.ctl, 1'b0});
            SEL_STS: reg_rdata = {29'd0, q.err, busy, q.done};
            default: reg_rdata = '0;
        endcase
    end

    assert_addr_held_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !abort_w) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    assert_write_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && !q.ctl[C_SINGLE] && !$past(bus_req && bus_we)) |-> $past(bus_ack && !bus_we));

    assert_done_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> $past(bus_ack));

    assert_count_no_rise_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (q.cnt <= $past(q.cnt)));

    assert_lane_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> ($countones(bus_be) == 1 || $countones(bus_be) == 2 || $countones(bus_be) == 4));

    assert_err_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |-> !bus_req);
endmodule

// File: tb/tb_dmx_chan.sv
`timescale 1ns/1ps
module tb_dmx_chan;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [2:0]  reg_sel;
    logic [31:0] reg_wdata, reg_rdata;
    logic        dreq;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic [3:0]  bus_be;
    logic        bus_ack;
    logic        irq;

    always #2.5 clk = ~clk;

    dmx_chan dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .irq(irq)
    );

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
    } xact_t;

    xact_t expq[$];
    int nchk = 0, nbad = 0;
    int lat = 0, wait_n = 0;
    logic cyc_open = 1'b0;
    logic [31:0] cur_addr;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat_byte(input logic [31:0] a);
        pat_byte = 8'(a[9:2] + 8'h10 * ({6'd0, a[1:0]} + 8'd1));
    endfunction

    function automatic logic [31:0] memword(input logic [31:0] a);
        memword = {pat_byte({a[31:2], 2'd3}), pat_byte({a[31:2], 2'd2}),
                   pat_byte({a[31:2], 2'd1}), pat_byte({a[31:2], 2'd0})};
    endfunction

    function automatic logic [3:0] mk_be(input int nb, input logic [1:0] lo);
        mk_be = 4'(((1 << nb) - 1) << lo);
    endfunction

    function automatic logic [31:0] mkctl(input bit go, reqen, steal, single, toio, sinc, dinc,
                                          input logic [1:0] ssz, dsz, input bit ie);
        mkctl = {20'd0, ie, dsz, ssz, dinc, sinc, toio, single, steal, reqen, go};
    endfunction

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ack  = 1'b0;
            cyc_open = 1'b0;
        end else if (bus_ack) begin
            bus_ack  = 1'b0;
            cyc_open = 1'b0;
        end else if (bus_req) begin
            if (!cyc_open) begin
                if (expq.size() == 0) begin
                    chk("R2 unexpected bus cycle", bus_addr, 32'hxxxx_xxxx);
                end else begin
                    xact_t e;
                    e = expq.pop_front();
                    chk("R2 direction", {31'd0, bus_we}, {31'd0, e.we});
                    chk("R2 address", bus_addr, e.addr);
                    chk("R3 byte enables", {28'd0, bus_be}, {28'd0, e.be});
                    chk("R3 write data", bus_wdata, e.data);
                end
                cur_addr = bus_addr;
                wait_n   = lat;
                cyc_open = 1'b1;
            end else begin
                chk("R14 address held", bus_addr, cur_addr);
            end
            if (wait_n == 0) begin
                bus_rdata = memword(bus_addr);
                bus_ack   = 1'b1;
            end else begin
                wait_n--;
            end
        end else begin
            cyc_open = 1'b0;
        end
    end

    task automatic push_dual(input logic [31:0] src, dst, input int cnt, nb, input bit sinc, dinc);
        for (int off = 0; off < cnt; off += nb) begin
            logic [31:0] s, dd, v;
            xact_t r, w;
            s  = src + (sinc ? off : 0);
            dd = dst + (dinc ? off : 0);
            v  = '0;
            for (int k = 0; k < nb; k++)
                v = v | (32'(pat_byte(s + k)) << (8 * (int'(dd[1:0]) + k)));
            r = '{we: 1'b0, addr: s, data: 32'd0, be: mk_be(nb, s[1:0])};
            w = '{we: 1'b1, addr: dd, data: v, be: mk_be(nb, dd[1:0])};
            expq.push_back(r);
            expq.push_back(w);
        end
    endtask

    task automatic push_single(input logic [31:0] a, input int cnt, nb, input bit inc, toio);
        for (int off = 0; off < cnt; off += nb) begin
            logic [31:0] x;
            xact_t t;
            x = a + (inc ? off : 0);
            t = '{we: !toio, addr: x, data: 32'd0, be: mk_be(nb, x[1:0])};
            expq.push_back(t);
        end
    endtask

    task automatic wreg(input logic [2:0] sel, input logic [31:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] sel, output logic [31:0] val);
        @(negedge clk);
        reg_sel = sel;
        #0.5;
        val = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 2000; i++) begin
            rreg(3'd4, v);
            if (!v[1]) break;
        end
    endtask

    task automatic pulse_dreq();
        @(negedge clk); dreq = 1'b1;
        @(negedge clk); dreq = 1'b0;
    endtask

    task automatic setup(input logic [31:0] s, dd, c);
        wreg(3'd0, s); wreg(3'd1, dd); wreg(3'd2, c);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; reg_we = 1'b0; reg_sel = 3'd0; reg_wdata = '0; dreq = 1'b0;
        bus_ack = 1'b0; bus_rdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rreg(3'd4, v); chk("R1 status after reset", v, 32'd0);
        rreg(3'd2, v); chk("R1 count after reset", v, 32'd0);
        rreg(3'd3, v); chk("R1 control after reset", v, 32'd0);
        chk("R1 bus_req after reset", {31'd0, bus_req}, 32'd0);
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);

        // dual byte transfer with lane steering, both stepping, interrupt on
        setup(32'h103, 32'h201, 32'd4);
        push_dual(32'h103, 32'h201, 4, 1, 1, 1);
        wreg(3'd3, mkctl(1, 0, 0, 0, 0, 1, 1, 2'd1, 2'd1, 1));
        wait_idle();
        rreg(3'd4, v); chk("R4 done after byte run", v, 32'd1);
        rreg(3'd2, v); chk("R4 count zero", v, 32'd0);
        rreg(3'd0, v); chk("R5 source stepped", v, 32'h107);
        rreg(3'd1, v); chk("R5 destination stepped", v, 32'h205);
        chk("R11 irq at done", {31'd0, irq}, 32'd1);
        chk("R8 all transfers seen", expq.size(), 0);
        wreg(3'd4, 32'd1);
        @(negedge clk);
        chk("R11 irq cleared", {31'd0, irq}, 32'd0);
        rreg(3'd4, v); chk("R10 done cleared", v, 32'd0);

        // 16-bit, static destination, no interrupt, slow acks
        lat = 3;
        setup(32'h112, 32'h300, 32'd6);
        push_dual(32'h112, 32'h300, 6, 2, 1, 0);
        wreg(3'd3, mkctl(1, 0, 0, 0, 0, 1, 0, 2'd2, 2'd2, 0));
        wait_idle();
        lat = 0;
        rreg(3'd1, v); chk("R5 static destination", v, 32'h300);
        rreg(3'd0, v); chk("R5 source after 16-bit", v, 32'h118);
        chk("R11 irq off when disabled", {31'd0, irq}, 32'd0);
        chk("R2 16-bit queue drained", expq.size(), 0);

        // 32-bit dual
        setup(32'h140, 32'h180, 32'd8);
        push_dual(32'h140, 32'h180, 8, 4, 1, 1);
        wreg(3'd3, mkctl(1, 0, 0, 0, 0, 1, 1, 2'd0, 2'd0, 0));
        wait_idle();
        rreg(3'd2, v); chk("R4 32-bit count zero", v, 32'd0);
        chk("R2 32-bit queue drained", expq.size(), 0);

        // single-address memory to I/O, 16-bit
        setup(32'h402, 32'h0, 32'd4);
        push_single(32'h402, 4, 2, 1, 1);
        wreg(3'd3, mkctl(1, 0, 0, 1, 1, 1, 0, 2'd2, 2'd2, 0));
        wait_idle();
        chk("R6 single reads done", expq.size(), 0);

        // single-address I/O to memory, byte
        setup(32'h0, 32'h501, 32'd2);
        push_single(32'h501, 2, 1, 1, 0);
        wreg(3'd3, mkctl(1, 0, 0, 1, 0, 0, 1, 2'd1, 2'd1, 0));
        wait_idle();
        chk("R6 single writes done", expq.size(), 0);
        rreg(3'd4, v); chk("R6 done after single", v, 32'd1);

        // cycle-steal
        setup(32'h600, 32'h700, 32'd3);
        push_dual(32'h600, 32'h700, 3, 1, 1, 1);
        wreg(3'd3, mkctl(1, 1, 1, 0, 0, 1, 1, 2'd1, 2'd1, 0));
        repeat (8) @(negedge clk);
        rreg(3'd2, v); chk("R7 armed without request", v, 32'd3);
        pulse_dreq();
        repeat (10) @(negedge clk);
        rreg(3'd2, v); chk("R7 one transfer per edge", v, 32'd2);
        chk("R7 bus idle between edges", {31'd0, bus_req}, 32'd0);
        pulse_dreq(); repeat (10) @(negedge clk);
        pulse_dreq(); repeat (10) @(negedge clk);
        rreg(3'd4, v); chk("R7 done after three edges", v, 32'd1);

        // continuous run started by one request edge
        setup(32'h620, 32'h720, 32'd6);
        push_dual(32'h620, 32'h720, 6, 2, 1, 1);
        wreg(3'd3, mkctl(1, 1, 0, 0, 0, 1, 1, 2'd2, 2'd2, 0));
        repeat (6) @(negedge clk);
        rreg(3'd2, v); chk("R8 waits for request", v, 32'd6);
        pulse_dreq();
        wait_idle();
        rreg(3'd2, v); chk("R8 one edge runs to zero", v, 32'd0);

        // request enable cleared while busy; writes while busy ignored
        setup(32'h640, 32'h740, 32'd2);
        push_dual(32'h640, 32'h740, 2, 1, 1, 1);
        wreg(3'd3, mkctl(1, 1, 1, 0, 0, 1, 1, 2'd1, 2'd1, 0));
        pulse_dreq();
        repeat (10) @(negedge clk);
        wreg(3'd3, mkctl(0, 0, 0, 1, 1, 0, 0, 2'd0, 2'd0, 1));
        rreg(3'd3, v); chk("R9 only request enable taken", v, mkctl(0, 0, 1, 0, 0, 1, 1, 2'd1, 2'd1, 0));
        wreg(3'd0, 32'hABC0);
        wreg(3'd2, 32'd40);
        rreg(3'd0, v); chk("R13 source write ignored", v, 32'h641);
        rreg(3'd2, v); chk("R13 count write ignored", v, 32'd1);
        pulse_dreq();
        repeat (10) @(negedge clk);
        rreg(3'd2, v); chk("R9 edge ignored", v, 32'd1);
        rreg(3'd4, v); chk("R9 still busy", v, 32'd2);
        wreg(3'd4, 32'd1);
        rreg(3'd4, v); chk("R10 abort to idle", v, 32'd0);
        expq.delete();

        // configuration errors
        setup(32'h100, 32'h200, 32'd3);
        wreg(3'd3, mkctl(1, 0, 0, 0, 0, 1, 1, 2'd2, 2'd2, 0));
        rreg(3'd4, v); chk("R12 count not multiple", v, 32'd4);
        chk("R12 no bus cycle", {31'd0, bus_req}, 32'd0);
        wreg(3'd2, 32'd4);
        wreg(3'd3, mkctl(1, 0, 0, 0, 0, 1, 1, 2'd3, 2'd3, 0));
        rreg(3'd4, v); chk("R12 size code 3", v, 32'd4);
        wreg(3'd3, mkctl(1, 0, 0, 0, 0, 1, 1, 2'd1, 2'd2, 0));
        rreg(3'd4, v); chk("R12 unequal sizes", v, 32'd4);
        wreg(3'd0, 32'h102);
        wreg(3'd3, mkctl(1, 0, 0, 0, 0, 1, 1, 2'd0, 2'd0, 0));
        rreg(3'd4, v); chk("R12 misaligned source", v, 32'd4);
        wreg(3'd2, 32'd0);
        wreg(3'd3, mkctl(1, 0, 0, 0, 0, 1, 1, 2'd1, 2'd1, 0));
        rreg(3'd4, v); chk("R12 zero count", v, 32'd4);
        chk("R12 no bus cycle on errors", expq.size(), 0);
        wreg(3'd4, 32'd1);
        rreg(3'd4, v); chk("R10 err cleared", v, 32'd0);

        // abort during a continuous run
        setup(32'h800, 32'h900, 32'd16);
        push_dual(32'h800, 32'h900, 16, 4, 1, 1);
        wreg(3'd3, mkctl(1, 0, 0, 0, 0, 1, 1, 2'd0, 2'd0, 0));
        repeat (2) @(negedge clk);
        wreg(3'd4, 32'd1);
        rreg(3'd4, v); chk("R10 abort clears busy", v, 32'd0);
        repeat (5) @(negedge clk);
        chk("R10 bus stays idle", {31'd0, bus_req}, 32'd0);
        rreg(3'd2, v); chk("R10 run cut short", {31'd0, v != 32'd0}, 32'd1);
        expq.delete();

        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule